// File: doc/BRIEF.md
# ADC Serial Readout Controller

This block is the host side of a select-plus-three-wire serial link to a delta-sigma converter that runs in externally clocked, single-cycle mode. A start request carries a configuration word. The controller then pulls chip select low while the serial clock is held low, which keeps the converter in external-clock mode. It watches the returned data line, where high means a conversion is running and low means a result is waiting. Once the line goes low it generates exactly 24 clock pulses. On these pulses it sends the configuration and collects the 24-bit result word, which begins with the status bit.

Settings written during a data cycle take effect only on the conversion that follows it. For this reason, each result is returned together with the configuration sent in the cycle before. After a cycle the controller either releases chip select, which lowers the converter's power, or keeps it low so that the next end of conversion can be watched without a new select edge. A programmable limit on polling ends a wait that takes too long: it sets an error flag and releases the converter. The serial clock half-period is a parameter, counted in system clock cycles.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `sclk` is low in every cycle where `csN` goes from 1 to 0, and `sclk` is never high while `csN` is high.
- R2: After select, no rising `sclk` edge occurs while `miso` is high (conversion running); clocking starts only after `miso` is sampled low.
- R3: A data cycle has exactly 24 rising `sclk` edges, and each high phase lasts `HALF_DIV` system clock cycles.
- R4: `cfgIn` is latched at an accepted start. It is presented on `mosi` most-significant bit first, stable across each rising edge from the first one. The edges after the `CFG_W` configuration bits carry 0.
- R5: `miso` is sampled at each rising edge. The first sample (the status bit) lands in `result[23]` and the 24th lands in `result[0]`.
- R6: `resultCfg` holds the configuration of the previous completed data cycle, and 0 for the first cycle after reset.
- R7: `resultValid` is a single-cycle pulse per completed data cycle. `result` and `resultCfg` hold their values after it.
- R8: When `holdSelect` is 1 at the accepted start, `csN` stays low after the data cycle. When it is 0, `csN` returns high.
- R9: If `miso` stays high for `eocTimeout`+1 consecutive polling cycles, `timeoutErr` is set, `csN` returns high and no result is produced. The next accepted start clears `timeoutErr`.
- R10: `busy` is high from the cycle after an accepted start until the cycle ends or times out. A `startReq` while busy is ignored: it neither changes the configuration being sent nor starts an extra cycle.
- R11: After reset, `csN`=1, `sclk`=0, `mosi`=0, `resultValid`=0, `busy`=0 and `timeoutErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one data cycle (accepted when not busy) |
| cfgIn | input | CFG_W | Configuration word to send |
| holdSelect | input | 1 | Keep select low after the cycle |
| eocTimeout | input | TO_W | Polling limit in system cycles |
| miso | input | 1 | Data line from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Configuration data to the converter |
| result | output | FRAME_BITS | Captured word, status bit first |
| resultCfg | output | CFG_W | Configuration that produced this result |
| resultValid | output | 1 | One-cycle result strobe |
| busy | output | 1 | A cycle or a poll is in progress |
| timeoutErr | output | 1 | Polling timed out |

## Verification
The assertions assume a converter that keeps `miso` high throughout a conversion and changes it only after falling `sclk` edges. They also assume that `eocTimeout` does not change while polling is in progress. The bench's converter model updates its output only on detected falling edges, holds the line high for a fixed conversion time, and can hold the line high indefinitely to force a timeout. The polling limit changes only while the controller is idle. Start requests are driven between clock edges, and one deliberately arrives in the middle of a data cycle.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_POLL,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } linkState_t;

  typedef struct packed {
    logic loadCfg;
    logic startShift;
    logic divRun;
    logic sample;
    logic nextBit;
    logic publish;
  } ctrlStrobes_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                holdSelect,
  input  logic [TO_W-1:0]     eocTimeout,
  input  logic                miso,
  input  logic                divTick,
  input  logic                lastBit,
  output ctrlStrobes_t        strb,
  output logic                csN,
  output logic                sclk,
  output logic                busy,
  output logic                timeoutErr
);

  linkState_t state, nextState;
  logic [TO_W-1:0] pollCnt;
  logic holdLat;
  logic timeoutHit;

  always_comb begin
    nextState  = state;
    strb       = '0;
    timeoutHit = 1'b0;
    unique case (state)
      ST_IDLE, ST_HOLD: begin
        if (startReq) begin
          strb.loadCfg = 1'b1;
          nextState    = ST_POLL;
        end
      end
      ST_POLL: begin
        if (!miso) begin
          strb.startShift = 1'b1;
          nextState       = ST_LOW;
        end else if (pollCnt == eocTimeout) begin
          timeoutHit = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      ST_LOW: begin
        strb.divRun = 1'b1;
        if (divTick) begin
          strb.sample = 1'b1;
          nextState   = ST_HIGH;
        end
      end
      ST_HIGH: begin
        strb.divRun = 1'b1;
        if (divTick) begin
          if (lastBit) begin
            nextState = ST_DONE;
          end else begin
            strb.nextBit = 1'b1;
            nextState    = ST_LOW;
          end
        end
      end
      ST_DONE: begin
        strb.publish = 1'b1;
        nextState    = holdLat ? ST_HOLD : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      csN        <= 1'b1;
      sclk       <= 1'b0;
      pollCnt    <= '0;
      holdLat    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state <= nextState;
      csN   <= (nextState == ST_IDLE);
      sclk  <= (nextState == ST_HIGH);
      if (state == ST_POLL && nextState == ST_POLL) pollCnt <= pollCnt + 1'b1;
      else                                          pollCnt <= '0;
      if (strb.loadCfg) holdLat <= holdSelect;
      if (strb.loadCfg)     timeoutErr <= 1'b0;
      else if (timeoutHit)  timeoutErr <= 1'b1;
    end
  end

  assign busy = !(state == ST_IDLE || state == ST_HOLD);

  // R1: the converter must see a low clock at the select edge
  assert_sclk_low_at_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);
  assert_no_clock_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R2: a busy line while polling never produces a clock edge
  assert_no_clock_while_converting_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL && miso) |=> !sclk);
  // R9: a timeout always releases the converter
  assert_timeout_releases_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> csN);
  // R8: the hold state keeps select asserted
  assert_hold_keeps_select_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> !csN);

endmodule

// File: rtl/adcrd_dpath.sv
module adcrd_dpath
  import adcrd_pkg::*;
#(
  parameter int                CFG_W      = 8,
  parameter int                FRAME_BITS = 24,
  parameter int                HALF_DIV   = 4,
  parameter logic [CFG_W-1:0]  CFG_RESET  = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [CFG_W-1:0]       cfgIn,
  input  logic                   miso,
  output logic                   divTick,
  output logic                   lastBit,
  output logic                   mosi,
  output logic [FRAME_BITS-1:0]  result,
  output logic [CFG_W-1:0]       resultCfg,
  output logic                   resultValid
);

  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [CFG_W-1:0]      cfgReg, prevCfg;
  logic [FRAME_BITS-1:0] shiftReg, frameBits;
  logic [BIT_W-1:0]      bitIdx;
  logic [DIV_W-1:0]      divCnt;

  generate
    if (CFG_W == FRAME_BITS) begin : g_fullCfg
      assign frameBits = cfgReg;
    end else begin : g_padCfg
      assign frameBits = {cfgReg, {(FRAME_BITS - CFG_W){1'b0}}};
    end
  endgenerate

  assign divTick = (divCnt == DIV_LAST);
  assign lastBit = (bitIdx == LAST_IDX);
  assign mosi    = strb.divRun ? frameBits[LAST_IDX - bitIdx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bitIdx <= '0;
    end else begin
      if (!strb.divRun || divTick) divCnt <= '0;
      else                         divCnt <= divCnt + 1'b1;
      if (strb.startShift)         bitIdx <= '0;
      else if (strb.nextBit)       bitIdx <= bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg      <= CFG_RESET;
      prevCfg     <= CFG_RESET;
      shiftReg    <= '0;
      result      <= '0;
      resultCfg   <= CFG_RESET;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.publish;
      if (strb.loadCfg) cfgReg <= cfgIn;
      if (strb.sample)  shiftReg <= {shiftReg[FRAME_BITS-2:0], miso};
      if (strb.publish) begin
        result    <= shiftReg;
        resultCfg <= prevCfg;
        prevCfg   <= cfgReg;
      end
    end
  end

  // R3: a result is published only after the final bit position
  assert_publish_after_last_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.publish |-> (bitIdx == LAST_IDX));
  assert_bit_index_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST_IDX);
  // R7: the valid strobe lasts exactly one cycle
  assert_valid_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R7: the published word holds after the strobe
  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resultValid) |-> $stable(result));

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adcrd_pkg::*;
#(
  parameter int                CFG_W      = 8,
  parameter int                FRAME_BITS = 24,
  parameter int                HALF_DIV   = 4,
  parameter int                TO_W       = 16,
  parameter logic [CFG_W-1:0]  CFG_RESET  = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [CFG_W-1:0]       cfgIn,
  input  logic                   holdSelect,
  input  logic [TO_W-1:0]        eocTimeout,
  input  logic                   miso,
  output logic                   csN,
  output logic                   sclk,
  output logic                   mosi,
  output logic [FRAME_BITS-1:0]  result,
  output logic [CFG_W-1:0]       resultCfg,
  output logic                   resultValid,
  output logic                   busy,
  output logic                   timeoutErr
);

  ctrlStrobes_t strb;
  logic divTick, lastBit;

  adcrd_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .holdSelect (holdSelect),
    .eocTimeout (eocTimeout),
    .miso       (miso),
    .divTick    (divTick),
    .lastBit    (lastBit),
    .strb       (strb),
    .csN        (csN),
    .sclk       (sclk),
    .busy       (busy),
    .timeoutErr (timeoutErr)
  );

  adcrd_dpath #(
    .CFG_W      (CFG_W),
    .FRAME_BITS (FRAME_BITS),
    .HALF_DIV   (HALF_DIV),
    .CFG_RESET  (CFG_RESET)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgIn       (cfgIn),
    .miso        (miso),
    .divTick     (divTick),
    .lastBit     (lastBit),
    .mosi        (mosi),
    .result      (result),
    .resultCfg   (resultCfg),
    .resultValid (resultValid)
  );

endmodule

// File: tb/test_adc_readout_ctrl.sv
`timescale 1ns/1ps
module test_adc_readout_ctrl;

  localparam int CFG_W = 8;
  localparam int FB = 24;
  localparam int HD = 2;
  localparam int TO_W = 16;
  localparam int CONV_LEN = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [CFG_W-1:0] cfgIn = '0;
  logic holdSelect = 1'b0;
  logic [TO_W-1:0] eocTimeout = 16'd200;
  logic miso;
  logic csN, sclk, mosi, resultValid, busy, timeoutErr;
  logic [FB-1:0] result;
  logic [CFG_W-1:0] resultCfg;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_readout_ctrl #(.CFG_W(CFG_W), .FRAME_BITS(FB), .HALF_DIV(HD), .TO_W(TO_W)) i_adc_readout_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgIn(cfgIn), .holdSelect(holdSelect),
    .eocTimeout(eocTimeout), .miso(miso), .csN(csN), .sclk(sclk), .mosi(mosi),
    .result(result), .resultCfg(resultCfg), .resultValid(resultValid), .busy(busy),
    .timeoutErr(timeoutErr)
  );

  function automatic logic [22:0] dataOf(input int k);
    logic [31:0] v;
    v = 32'(k) * 32'h0001F3D5 + 32'h5A5;
    return v[22:0];
  endfunction

  // converter model, evaluated between clock edges
  logic mBusy, stuck;
  int mTimer, convIdx, fallCnt, riseTotal, validTotal, highRun;
  int selViol, pollViol, phaseViol;
  logic [FB-1:0] outWord, capCfg, lastCap;
  logic sclkQ, csQ;

  assign miso = csN ? 1'b1 : (mBusy ? 1'b1 : outWord[FB-1]);

  always @(negedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mTimer <= 0; convIdx <= 0; fallCnt <= 0;
      outWord <= {1'b0, dataOf(0)}; capCfg <= '0; lastCap <= '0;
      sclkQ <= 1'b0; csQ <= 1'b1; riseTotal <= 0; validTotal <= 0; highRun <= 0;
      selViol <= 0; pollViol <= 0; phaseViol <= 0;
    end else begin
      sclkQ <= sclk;
      csQ <= csN;
      if (csN && sclk) selViol <= selViol + 1;
      if (csQ && !csN && sclk) selViol <= selViol + 1;
      if (resultValid) validTotal <= validTotal + 1;
      if (sclk) highRun <= highRun + 1; else highRun <= 0;
      if (sclk && !sclkQ) begin
        riseTotal <= riseTotal + 1;
        capCfg <= {capCfg[FB-2:0], mosi};
        if (mBusy) pollViol <= pollViol + 1;
      end
      if (!sclk && sclkQ) begin
        if (highRun != HD) phaseViol <= phaseViol + 1;
        outWord <= {outWord[FB-2:0], 1'b1};
        if (fallCnt == FB - 1) begin
          fallCnt <= 0;
          mBusy <= 1'b1;
          mTimer <= CONV_LEN;
          convIdx <= convIdx + 1;
          lastCap <= capCfg;
        end else begin
          fallCnt <= fallCnt + 1;
        end
      end else if (mBusy) begin
        if (mTimer > 0) mTimer <= mTimer - 1;
        else if (!stuck) begin
          mBusy <= 1'b0;
          outWord <= {1'b0, dataOf(convIdx)};
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int frameNo = 0;
  logic [CFG_W-1:0] prevExp = '0;

  task automatic doFrame(input logic [CFG_W-1:0] cfg, input bit hold, input bit interfere);
    int riseBase, n;
    bit got, poked;
    riseBase = riseTotal;
    got = 0; poked = 0;
    @(negedge clk);
    startReq = 1'b1; cfgIn = cfg; holdSelect = hold;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", 32'(busy), 1);
    chk(timeoutErr === 1'b0, "R9 error cleared by start", 32'(timeoutErr), 0);
    for (n = 0; n < 3000 && !got; n++) begin
      @(negedge clk);
      startReq = 1'b0;
      if (resultValid) got = 1;
      else if (interfere && !poked && (riseTotal - riseBase) == 3) begin
        startReq = 1'b1; cfgIn = ~cfg; holdSelect = ~hold; poked = 1;
      end
    end
    startReq = 1'b0;
    chk(got, "R7 result strobe seen", 32'(got), 1);
    chk(result === {1'b0, dataOf(frameNo)}, "R5 result word", 32'(result), 32'({1'b0, dataOf(frameNo)}));
    chk(resultCfg === prevExp, "R6 previous config tag", 32'(resultCfg), 32'(prevExp));
    chk(lastCap === {cfg, 16'h0}, "R4 config bits on mosi", 32'(lastCap), 32'({cfg, 16'h0}));
    chk((riseTotal - riseBase) == FB, "R3 rising edges per cycle", 32'(riseTotal - riseBase), FB);
    @(negedge clk);
    chk(resultValid === 1'b0, "R7 strobe one cycle", 32'(resultValid), 0);
    chk(result === {1'b0, dataOf(frameNo)}, "R7 result held", 32'(result), 32'({1'b0, dataOf(frameNo)}));
    repeat (2) @(negedge clk);
    chk(csN === !hold, "R8 select after cycle", 32'(csN), 32'(!hold));
    chk(busy === 1'b0, "R10 busy ends", 32'(busy), 0);
    frameNo++;
    prevExp = cfg;
  endtask

  initial begin
    stuck = 1'b0;
    repeat (4) @(negedge clk);
    chk(csN === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R11 reset link pins", {29'b0, csN, sclk, mosi}, 32'b100);
    chk(resultValid === 1'b0 && busy === 1'b0 && timeoutErr === 1'b0, "R11 reset flags",
        {29'b0, resultValid, busy, timeoutErr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // sweep of configuration patterns and select-release modes
    for (int i = 0; i < 12; i++) doFrame(8'(i * 37 + 5), i[1], 1'b0);

    // start request in the middle of a cycle is ignored (R10)
    doFrame(8'hC3, 1'b0, 1'b1);
    repeat (30) @(negedge clk);
    chk(csN === 1'b1 && busy === 1'b0, "R10 no extra cycle", {30'b0, csN, busy}, 32'b10);

    // polling timeout while the converter never finishes (R9)
    doFrame(8'h5A, 1'b0, 1'b0);
    stuck = 1'b1;
    eocTimeout = 16'd20;
    begin
      int vBase;
      vBase = validTotal;
      @(negedge clk); startReq = 1'b1; cfgIn = 8'hEE; holdSelect = 1'b1;
      @(negedge clk); startReq = 1'b0;
      repeat (10) @(negedge clk);
      chk(timeoutErr === 1'b0 && csN === 1'b0, "R9 no early timeout", {30'b0, timeoutErr, csN}, 0);
      repeat (30) @(negedge clk);
      chk(timeoutErr === 1'b1, "R9 timeout flag", 32'(timeoutErr), 1);
      chk(csN === 1'b1 && busy === 1'b0, "R9 select released", {30'b0, csN, busy}, 32'b10);
      chk(validTotal == vBase, "R9 no result on timeout", 32'(validTotal - vBase), 0);
    end
    stuck = 1'b0;
    eocTimeout = 16'd200;
    doFrame(8'h81, 1'b1, 1'b0);
    doFrame(8'h7E, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    chk(selViol == 0, "R1 clock low at select", 32'(selViol), 0);
    chk(pollViol == 0, "R2 no clock during conversion", 32'(pollViol), 0);
    chk(phaseViol == 0, "R3 high phase length", 32'(phaseViol), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule